// File: doc/BRIEF.md
# Serial Audio Slot Width Adapter

This block re-emits a stereo serial audio stream (bit clock, word select, data) toward an external processor. The frame shape on the output depends on where the stream came from. An internal decoder stream always leaves as 32 clock pulses per channel that carry 18 valid bits followed by zero fill. An external digital source keeps its own frame shape unless it is longer than the output can carry. In that case the output is cut down to 32 pulses per channel and 18 valid bits.

The block runs on a fast system clock and oversamples the incoming bit clock. Each input bit is re-issued one bit-clock period later. Bits beyond the valid width are forced to zero. Surplus clock pulses are removed. A per-channel width meter lets the output word select turn on the last pulse that is kept. An enable input parks all three outputs low when the port is unused, which keeps the lines quiet for emission reasons. Word select low is the left channel and high is the right channel. Data is sent MSB first, one bit clock after the word-select transition.

Top module: `slot_width_adapter`

## Requirements
- R1: While `rst_n` is low, `out_bclk`, `out_ws` and `out_sd` are all 0.
- R2: With `src_ext` = 0 (internal source) and a 32-clock input slot, every channel leaves as 32 pulses. The first 18 bits are copied MSB first and the remaining 14 are 0. `ext_bits` has no effect in this mode.
- R3: With `src_ext` = 1, `ext_bits` ≥ 18 and more than 32 input clocks per channel, each channel leaves as exactly 32 pulses. Only the first 18 of them carry input data and the rest are 0.
- R4: With `src_ext` = 1, `ext_bits` ≥ 18 and 18 to 32 input clocks per channel, every input clock is re-issued. The first 18 bits are copied and the later ones are 0.
- R5: With `src_ext` = 1 and `ext_bits` < 18, every input clock is re-issued, whatever the slot length. The first `ext_bits` bits are copied and the later ones are 0.
- R6: Each kept output pulse carries the word select and data that the input presented one input bit clock earlier. Bit order and channel order are kept, so the output word select still turns one pulse before each MSB.
- R7: When a channel is cut to 32 pulses, the output word select turns on its 32nd pulse, provided the previous slot of the same channel measured more than 32 clocks. On the first such slot after reset, it stays at the old channel for all 32 pulses.
- R8: One system clock after `out_en` goes low, all three outputs are held at 0. While the port is enabled, `out_ws` and `out_sd` change only while `out_bclk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial input |
| rst_n | input | 1 | Active-low synchronous reset |
| src_ext | input | 1 | Source kind: 0 internal decoder, 1 external source |
| ext_bits | input | CNT_W (6) | Valid bits per word of the external source |
| in_bclk | input | 1 | Input bit clock |
| in_ws | input | 1 | Input word select (0 left, 1 right) |
| in_sd | input | 1 | Input serial data, MSB first |
| out_en | input | 1 | Output port enable; 0 parks the outputs low |
| out_bclk | output | 1 | Output bit clock, with surplus pulses removed |
| out_ws | output | 1 | Output word select |
| out_sd | output | 1 | Output serial data |

## Verification
The main function is driven with random data words in slots of 16, 18, 24, 32, 33, 40 and 48 clocks, paired with valid widths below, at and above 18.

- The 32-clock internal slot, driven while `ext_bits` is set to 5, shows whether the source select overrides the external width.
- The 33- and 48-clock slots separate cutting from pass-through and show whether the 32-pulse cap starts at the right count.
- Running three frames in a row shows the word select staying put on the first cut slot and then turning early once a width has been measured.
- The 18-clock case and the 40-clock slot with 12 valid bits show that the cap only applies at 18 valid bits or more.

// File: rtl/sa_pkg.sv
package sa_pkg;

   // source kind selected at the block edge
   typedef enum logic {
      SRC_INT = 1'b0,
      SRC_EXT = 1'b1
   } sa_src_e;

   // one captured bit waiting to be re-issued
   typedef struct packed {
      logic emit;
      logic ws;
      logic sd;
   } sa_bit_t;

endpackage

// File: rtl/sa_edge_sync.sv
module sa_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk_i,
   input  logic ws_i,
   input  logic sd_i,
   output logic rise_o,
   output logic fall_o,
   output logic ws_o,
   output logic sd_o
);

   logic b_s;
   logic b_d;

   generate
      if (STAGES == 0) begin : g_direct
         // inputs already synchronous to clk
         assign b_s  = bclk_i;
         assign ws_o = ws_i;
         assign sd_o = sd_i;
      end else begin : g_chain
         logic [STAGES-1:0] b_sr;
         logic [STAGES-1:0] w_sr;
         logic [STAGES-1:0] d_sr;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               b_sr <= '0;
               w_sr <= '0;
               d_sr <= '0;
            end else begin
               b_sr <= (b_sr << 1) | STAGES'(bclk_i);
               w_sr <= (w_sr << 1) | STAGES'(ws_i);
               d_sr <= (d_sr << 1) | STAGES'(sd_i);
            end
         end

         assign b_s  = b_sr[STAGES-1];
         assign ws_o = w_sr[STAGES-1];
         assign sd_o = d_sr[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) b_d <= 1'b0;
      else        b_d <= b_s;
   end

   assign rise_o = b_s & ~b_d;
   assign fall_o = ~b_s & b_d;

endmodule

// File: rtl/sa_slot_meter.sv
module sa_slot_meter #(
   parameter int MAX_CLKS = 63,
   parameter int CW       = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rise_i,
   input  logic          ws_i,
   output logic [CW-1:0] idx_o,
   output logic          chan_o,
   output logic [CW-1:0] width_o
);

   localparam logic [CW-1:0] TOP = CW'(MAX_CLKS);

   logic          ws_q;
   logic [CW-1:0] idx_q;
   logic [CW-1:0] meas_q [2];
   logic          turn;

   // the bit sampled when word select differs is the last of the old slot
   assign turn = rise_i && (ws_i != ws_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ws_q  <= 1'b0;
         idx_q <= '0;
      end else if (rise_i) begin
         ws_q <= ws_i;
         if (ws_i != ws_q)  idx_q <= '0;
         else if (idx_q != TOP) idx_q <= idx_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < 2; c++) meas_q[c] <= '0;
      end else begin
         for (int c = 0; c < 2; c++) begin
            if (turn && (ws_q == c[0]))
               meas_q[c] <= (idx_q == TOP) ? TOP : idx_q + 1'b1;
         end
      end
   end

   assign idx_o   = idx_q;
   assign chan_o  = ws_q;
   assign width_o = meas_q[ws_q];

endmodule

// File: rtl/sa_slot_formatter.sv
module sa_slot_formatter
   import sa_pkg::*;
#(
   parameter int SLOT_CLKS  = 32,
   parameter int VALID_BITS = 18,
   parameter int CW         = 6,
   parameter bit OUT_REG    = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rise_i,
   input  logic          fall_i,
   input  logic          ws_i,
   input  logic          sd_i,
   input  logic [CW-1:0] idx_i,
   input  logic          chan_i,
   input  logic [CW-1:0] width_i,
   input  sa_src_e       src_i,
   input  logic [CW-1:0] ext_bits_i,
   input  logic          oe_i,
   output logic          bclk_o,
   output logic          ws_o,
   output logic          sd_o
);

   localparam logic [CW-1:0] SLOT_C  = CW'(SLOT_CLKS);
   localparam logic [CW-1:0] LAST_C  = CW'(SLOT_CLKS - 1);
   localparam logic [CW-1:0] VALID_C = CW'(VALID_BITS);

   logic          d_ge;
   logic [CW-1:0] bits_lim;
   logic          emit_n;
   logic          turn_n;
   sa_bit_t       next_bit;
   sa_bit_t       hold_q;
   logic          ln_bclk;
   logic          ln_ws;
   logic          ln_sd;

   always_comb begin
      d_ge     = (src_i == SRC_INT) || (ext_bits_i >= VALID_C);
      bits_lim = d_ge ? VALID_C : ext_bits_i;
      emit_n   = !(d_ge && (idx_i >= SLOT_C));
      turn_n   = d_ge && (width_i > SLOT_C) && (idx_i == LAST_C);
      next_bit.emit = emit_n;
      next_bit.ws   = turn_n ? ~chan_i : ws_i;
      next_bit.sd   = (idx_i < bits_lim) ? sd_i : 1'b0;
   end

   // one bit of delay: captured on an input rise, put on the line at the
   // next fall, clocked out at the rise after that
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q  <= '0;
         ln_bclk <= 1'b0;
         ln_ws   <= 1'b0;
         ln_sd   <= 1'b0;
      end else if (rise_i) begin
         ln_bclk <= hold_q.emit;
         hold_q  <= next_bit;
      end else if (fall_i) begin
         ln_bclk <= 1'b0;
         if (hold_q.emit) begin
            ln_ws <= hold_q.ws;
            ln_sd <= hold_q.sd;
         end
      end
   end

   generate
      if (OUT_REG) begin : g_reg_out
         always_ff @(posedge clk) begin
            if (!rst_n || !oe_i) begin
               bclk_o <= 1'b0;
               ws_o   <= 1'b0;
               sd_o   <= 1'b0;
            end else begin
               bclk_o <= ln_bclk;
               ws_o   <= ln_ws;
               sd_o   <= ln_sd;
            end
         end
      end else begin : g_comb_out
         assign bclk_o = ln_bclk & oe_i;
         assign ws_o   = ln_ws & oe_i;
         assign sd_o   = ln_sd & oe_i;
      end
   endgenerate

endmodule

// File: rtl/slot_width_adapter.sv
module slot_width_adapter
   import sa_pkg::*;
#(
   parameter int SLOT_CLKS   = 32,
   parameter int VALID_BITS  = 18,
   parameter int MAX_CLKS    = 63,
   parameter int CNT_W       = $clog2(MAX_CLKS + 1),
   parameter int SYNC_STAGES = 2,
   parameter bit OUT_REG     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src_ext,
   input  logic [CNT_W-1:0] ext_bits,
   input  logic             in_bclk,
   input  logic             in_ws,
   input  logic             in_sd,
   input  logic             out_en,
   output logic             out_bclk,
   output logic             out_ws,
   output logic             out_sd
);

   generate
      if (VALID_BITS < 1 || VALID_BITS > SLOT_CLKS) begin : g_bad_valid
         $error("VALID_BITS must lie in 1..SLOT_CLKS");
      end
      if (SLOT_CLKS >= MAX_CLKS) begin : g_bad_slot
         $error("SLOT_CLKS must be below MAX_CLKS");
      end
      if (CNT_W < $clog2(MAX_CLKS + 1)) begin : g_bad_cw
         $error("CNT_W too narrow for MAX_CLKS");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic             rise;
   logic             fall;
   logic             s_ws;
   logic             s_sd;
   logic [CNT_W-1:0] idx;
   logic             chan;
   logic [CNT_W-1:0] width;
   sa_src_e          src;

   assign src = sa_src_e'(src_ext);

   sa_edge_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .bclk_i (in_bclk),
      .ws_i   (in_ws),
      .sd_i   (in_sd),
      .rise_o (rise),
      .fall_o (fall),
      .ws_o   (s_ws),
      .sd_o   (s_sd)
   );

   sa_slot_meter #(
      .MAX_CLKS (MAX_CLKS),
      .CW       (CNT_W)
   ) u_meter (
      .clk     (clk),
      .rst_n   (rst_n),
      .rise_i  (rise),
      .ws_i    (s_ws),
      .idx_o   (idx),
      .chan_o  (chan),
      .width_o (width)
   );

   sa_slot_formatter #(
      .SLOT_CLKS  (SLOT_CLKS),
      .VALID_BITS (VALID_BITS),
      .CW         (CNT_W),
      .OUT_REG    (OUT_REG)
   ) u_fmt (
      .clk        (clk),
      .rst_n      (rst_n),
      .rise_i     (rise),
      .fall_i     (fall),
      .ws_i       (s_ws),
      .sd_i       (s_sd),
      .idx_i      (idx),
      .chan_i     (chan),
      .width_i    (width),
      .src_i      (src),
      .ext_bits_i (ext_bits),
      .oe_i       (out_en),
      .bclk_o     (out_bclk),
      .ws_o       (out_ws),
      .sd_o       (out_sd)
   );

endmodule

// File: rtl/sa_adapter_chk.sv
module sa_adapter_chk #(
   parameter int SLOT_CLKS  = 32,
   parameter int VALID_BITS = 18,
   parameter int CNT_W      = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             src_ext,
   input logic [CNT_W-1:0] ext_bits,
   input logic             out_en,
   input logic             out_bclk,
   input logic             out_ws,
   input logic             out_sd
);

   localparam logic [CNT_W-1:0] SLOT_C  = CNT_W'(SLOT_CLKS);
   localparam logic [CNT_W-1:0] VALID_C = CNT_W'(VALID_BITS);
   localparam logic [CNT_W-1:0] TOP_C   = '1;

   logic             prev_bclk;
   logic             last_ws;
   logic [CNT_W-1:0] run_cnt;
   logic [CNT_W-1:0] pos;
   logic             pulse;
   logic             cap_mode;
   logic [CNT_W-1:0] lim;

   assign pulse    = out_bclk && !prev_bclk;
   assign cap_mode = !src_ext || (ext_bits >= VALID_C);
   assign lim      = cap_mode ? VALID_C : ext_bits;

   // pulses seen at a constant word select, and bit position in the slot
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_bclk <= 1'b0;
         last_ws   <= 1'b0;
         run_cnt   <= '0;
         pos       <= '0;
      end else begin
         prev_bclk <= out_bclk;
         if (pulse) begin
            last_ws <= out_ws;
            if (out_ws != last_ws) begin
               run_cnt <= CNT_W'(1);
               pos     <= '0;
            end else begin
               if (run_cnt != TOP_C) run_cnt <= run_cnt + 1'b1;
               if (pos != TOP_C)     pos     <= pos + 1'b1;
            end
         end
      end
   end

   assert_quiet_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_en && !$past(out_en)) |-> (!out_bclk && !out_ws && !out_sd));

   assert_stable_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_en && $past(out_en) && $past(out_bclk) && out_bclk)
         |-> ($stable(out_sd) && $stable(out_ws)));

   // R2 and R3: no more than one slot worth of pulses at one word select
   assert_slot_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse && cap_mode && (out_ws == last_ws)) |-> (run_cnt < SLOT_C));

   // R2, R4 and R5: fill beyond the valid width is zero
   assert_pad_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse && (out_ws == last_ws) && (pos >= lim)) |-> !out_sd);

endmodule

bind slot_width_adapter sa_adapter_chk #(
   .SLOT_CLKS  (SLOT_CLKS),
   .VALID_BITS (VALID_BITS),
   .CNT_W      (CNT_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .src_ext  (src_ext),
   .ext_bits (ext_bits),
   .out_en   (out_en),
   .out_bclk (out_bclk),
   .out_ws   (out_ws),
   .out_sd   (out_sd)
);

// File: tb/test_slot_width_adapter.sv
`timescale 1ns/1ps
module test_slot_width_adapter;

   localparam int H = 4;   // system clocks per half input bit clock

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       src_ext = 1'b0;
   logic [5:0] ext_bits = '0;
   logic       in_bclk = 1'b0;
   logic       in_ws = 1'b0;
   logic       in_sd = 1'b0;
   logic       out_en = 1'b1;
   logic       out_bclk;
   logic       out_ws;
   logic       out_sd;

   int   checks = 0;
   int   fails  = 0;
   bit   oe_watch = 1'b0;
   logic prev_ob = 1'b0;
   logic [1:0] rxq  [$];
   logic [1:0] expq [$];

   always #2 clk = ~clk;

   slot_width_adapter i_slot_width_adapter (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_ext  (src_ext),
      .ext_bits (ext_bits),
      .in_bclk  (in_bclk),
      .in_ws    (in_ws),
      .in_sd    (in_sd),
      .out_en   (out_en),
      .out_bclk (out_bclk),
      .out_ws   (out_ws),
      .out_sd   (out_sd)
   );

   // receiver and per-clock observer, away from the active edge
   always @(negedge clk) begin
      if (out_bclk && !prev_ob) rxq.push_back({out_ws, out_sd});
      prev_ob = out_bclk;
      if (oe_watch) begin
         checks++;
         if ({out_bclk, out_ws, out_sd} != 3'b000) begin
            fails++;
            $display("FAIL R8 disabled port: got %b expected 000",
                     {out_bclk, out_ws, out_sd});
         end
      end
   end

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R6 watchdog: run exceeded %0d cycles, expected to finish earlier", 150000);
      summary();
      $finish;
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(logic ws, logic sd);
      in_ws   = ws;
      in_sd   = sd;
      in_bclk = 1'b0;
      tick(H);
      in_bclk = 1'b1;
      tick(H);
   endtask

   task automatic do_reset();
      rst_n   = 1'b0;
      in_bclk = 1'b0;
      in_ws   = 1'b0;
      in_sd   = 1'b0;
      tick(4);
      rst_n = 1'b1;
      tick(2);
      rxq.delete();
   endtask

   task automatic check_bit(string tag, int i, logic [1:0] got, logic [1:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s pulse %0d: got ws,sd=%b expected %b", tag, i, got, exp);
      end
   endtask

   // reference: frames of n clocks per channel, d valid bits
   task automatic run_case(string tag, logic ext, int n, int d, int frames);
      int prevn [2];
      src_ext  = ext;
      ext_bits = 6'(d);
      do_reset();
      expq.delete();
      prevn[0] = 0;
      prevn[1] = 0;
      for (int f = 0; f < frames; f++) begin
         for (int c = 0; c < 2; c++) begin
            logic [63:0] w;
            logic        nc;
            logic        ws_e;
            logic        sd_e;
            bit          dge;
            bit          cut;
            int          lim;
            int          cnt;
            w   = {$urandom(), $urandom()};
            nc  = (c == 0);
            dge = !ext || (d >= 18);
            cut = dge && (n > 32);
            lim = dge ? 18 : d;
            cnt = cut ? 32 : n;
            for (int k = 0; k < cnt; k++) begin
               ws_e = c[0];
               if (k == cnt - 1 && (!cut || prevn[c] > 32)) ws_e = nc;
               sd_e = (k < lim) ? w[63-k] : 1'b0;
               expq.push_back({ws_e, sd_e});
            end
            for (int k = 0; k < n; k++)
               send_bit((k == n - 1) ? nc : c[0], w[63-k]);
            prevn[c] = n;
         end
      end
      for (int k = 0; k < 4; k++) send_bit(1'b0, 1'b0);
      tick(4);
      for (int i = 0; i < expq.size(); i++) begin
         if (i >= rxq.size()) check_bit(tag, i, 2'bxx, expq[i]);
         else                 check_bit(tag, i, rxq[i], expq[i]);
      end
   endtask

   initial begin
      // R1: outputs low during reset
      tick(3);
      checks++; if (out_bclk !== 1'b0) begin fails++; $display("FAIL R1 out_bclk: got %b expected 0", out_bclk); end
      checks++; if (out_ws   !== 1'b0) begin fails++; $display("FAIL R1 out_ws: got %b expected 0", out_ws); end
      checks++; if (out_sd   !== 1'b0) begin fails++; $display("FAIL R1 out_sd: got %b expected 0", out_sd); end

      run_case("R2/R6 internal, ext_bits ignored", 1'b0, 32, 5, 3);
      run_case("R3/R7 ext 48 clk 24 bit",           1'b1, 48, 24, 3);
      run_case("R3 ext 33 clk 18 bit",              1'b1, 33, 18, 2);
      run_case("R4 ext 32 clk 32 bit",              1'b1, 32, 32, 2);
      run_case("R4 ext 24 clk 20 bit",              1'b1, 24, 20, 2);
      run_case("R4 ext 18 clk 18 bit",              1'b1, 18, 18, 2);
      run_case("R5 ext 16 clk 16 bit",              1'b1, 16, 16, 2);
      run_case("R5 ext 40 clk 12 bit",              1'b1, 40, 12, 2);

      // R8: disabled port stays low and issues no pulses
      src_ext  = 1'b1;
      ext_bits = 6'd20;
      out_en   = 1'b0;
      do_reset();
      oe_watch = 1'b1;
      for (int c = 0; c < 2; c++)
         for (int k = 0; k < 24; k++)
            send_bit((k == 23) ? (c == 0) : c[0], k[0]);
      oe_watch = 1'b0;
      checks++;
      if (rxq.size() != 0) begin
         fails++;
         $display("FAIL R8 pulses while disabled: got %0d expected 0", rxq.size());
      end
      out_en = 1'b1;

      summary();
      $finish;
   end

endmodule